// File: doc/BRIEF.md
# Burst-Addressed Synchronous SRAM Core

This block models a single-port synchronous SRAM with 18-bit words, each made of two 9-bit byte lanes. The array depth is a parameter. An internal two-bit burst counter latches a starting address from either of two address strobes. It then walks four word addresses within the aligned group of four, in linear or interleaved order. The upper address bits stay fixed for the whole burst.

Reads flow through: the word at the current counter address drives `dout` combinationally, with no output register, in the same cycle the address is registered. Writes take effect at the rising edge, at the address the counter holds during that cycle. A global write covers every lane; otherwise each lane is written only when the byte-write enable and that lane's select are both asserted. A sleep input freezes the block and suppresses both reads and writes.

Separate `din` and `dout` ports stand in for a bidirectional bus. The `dout_vld` flag marks the cycles in which the bus would be driven.

Top module: `sync_burst_sram`

## Requirements
- R1: A rising edge with `ce_n` low and either strobe low (`strobe_cpu_n` or `strobe_ctl_n`) loads `addr` as the burst start. From that edge onward, `dout` shows the word at that address in the same cycle, with no added register.
- R2: With `order_sel` = 0 (linear), the low two bits of the current address are (start low bits + beat count) modulo 4.
- R3: With `order_sel` = 1 (interleaved), the low two bits of the current address are (start low bits XOR beat count).
- R4: The beat count steps by one on an edge where `step_n` is low and no strobe is asserted. When `step_n` is high, the beat count holds.
- R5: After the fourth beat, a further step returns to the starting address. Address bits above bit 1 never change during a burst.
- R6: A strobe reloads the counter whatever the value of `step_n`. A strobe taken while `ce_n` is high deselects the block, and `dout_vld` stays low until the next selecting load.
- R7: While the block is selected, an edge with `wr_all_n` low writes both lanes of `din` to the current address. Lane 0 is `din[8:0]` and lane 1 is `din[17:9]`.
- R8: With `wr_all_n` high, lane b is written only when `byte_wr_en_n` is low and `byte_sel_n[b]` is low. Lanes not written keep their contents.
- R9: `dout_vld` is high exactly when the block is selected, `oe_n` is low, no write is requested and `sleep` is low. It follows `oe_n` without waiting for a clock. While `dout_vld` is low, `dout` is zero.
- R10: An edge with `sleep` high performs no write and does not change the counter or the selection. `dout_vld` is low while `sleep` is high.
- R11: After synchronous reset the block is deselected and `dout_vld` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | AW | Burst start address |
| ce_n | input | 1 | Chip enable, active low, sampled with a strobe |
| strobe_cpu_n | input | 1 | Processor-side address strobe, active low |
| strobe_ctl_n | input | 1 | Controller-side address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_sel | input | 1 | Burst order: 0 linear, 1 interleaved |
| wr_all_n | input | 1 | Global write, active low |
| byte_wr_en_n | input | 1 | Byte-write enable, active low |
| byte_sel_n | input | 2 | Per-lane write selects, active low |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| sleep | input | 1 | Power-down, active high |
| din | input | 18 | Write data |
| dout | output | 18 | Flow-through read data |
| dout_vld | output | 1 | Read data driven |

## Verification
A load or step takes effect at the edge, and the new word is already on `dout` in the cycle that follows that edge. The bench drives inputs just after each rising edge and samples outputs a few time units later, inside that same cycle. A write lands at the edge that closes its cycle, so its data is checked in the next cycle or on a later visit to the same address. `dout_vld` reacts to `oe_n` and the write controls within the cycle, so it is compared against the reference model every cycle, with no delay.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
    localparam int BYTE_W = 9;
    localparam int NBYTES = 2;
    localparam int WORD_W = BYTE_W * NBYTES;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } burst_order_e;

    typedef struct packed {
        logic       active;
        logic [1:0] beat;
    } ctr_state_t;

    typedef struct packed {
        logic [NBYTES-1:0] lane;
        logic              any;
    } wr_req_t;

    function automatic logic [1:0] beat_offset(input logic [1:0] start,
                                               input logic [1:0] beat,
                                               input burst_order_e ord);
        return (ord == ORD_INTERLEAVE) ? (start ^ beat) : (start + beat);
    endfunction
endpackage

// File: rtl/sbs_burst_ctr.sv
module sbs_burst_ctr
    import sbs_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hold,
    input  logic          load,
    input  logic          sel,
    input  logic          step,
    input  burst_order_e  ord,
    input  logic [AW-1:0] addr_in,
    output logic [AW-1:0] cur_addr,
    output logic          active
);
    ctr_state_t    st;
    logic [AW-1:0] base;

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            base <= '0;
        end else if (!hold) begin
            if (load) begin
                base      <= addr_in;
                st.beat   <= 2'd0;
                st.active <= sel;
            end else if (step) begin
                st.beat <= st.beat + 2'd1;
            end
        end
    end

    assign cur_addr = {base[AW-1:2], beat_offset(base[1:0], st.beat, ord)};
    assign active   = st.active;

    AST_LOAD_BEAT0: assert property (@(posedge clk) disable iff (rst)
        (load && !hold) |=> (st.beat == 2'd0)) else $error("load beat");   // R6
    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (rst)
        (!load && !step) |=> $stable(st.beat)) else $error("hold beat");    // R4
    AST_SLEEP_FREEZE: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(base) && $stable(st))) else $error("sleep");      // R10
    AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (rst)
        (!load && st.active) |=> $stable(cur_addr[AW-1:2])) else $error("upper"); // R5
endmodule

// File: rtl/sbs_wr_dec.sv
module sbs_wr_dec
    import sbs_pkg::*;
(
    input  logic              wr_all_n,
    input  logic              byte_wr_en_n,
    input  logic [NBYTES-1:0] byte_sel_n,
    output wr_req_t           req
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        assign req.lane[g] = !wr_all_n || (!byte_wr_en_n && !byte_sel_n[g]);
    end
    assign req.any = |req.lane;

    always_comb begin
        if (wr_all_n == 1'b0) begin
            AST_GW_ALL: assert (&req.lane) else $error("global write");     // R7
        end
        if (byte_wr_en_n == 1'b1 && wr_all_n == 1'b1) begin
            AST_BWE_OFF: assert (!req.any) else $error("byte enable off");   // R8
        end
    end
endmodule

// File: rtl/sbs_array.sv
module sbs_array
    import sbs_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic [NBYTES-1:0] we,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);
    for (genvar g = 0; g < NBYTES; g++) begin : g_lane
        logic [BYTE_W-1:0] mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we[g]) mem[addr] <= wdata[g*BYTE_W +: BYTE_W];
        end
        assign rdata[g*BYTE_W +: BYTE_W] = mem[addr];
    end
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [AW-1:0]     addr,
    input  logic              ce_n,
    input  logic              strobe_cpu_n,
    input  logic              strobe_ctl_n,
    input  logic              step_n,
    input  logic              order_sel,
    input  logic              wr_all_n,
    input  logic              byte_wr_en_n,
    input  logic [1:0]        byte_sel_n,
    input  logic              oe_n,
    input  logic              sleep,
    input  logic [17:0]       din,
    output logic [17:0]       dout,
    output logic              dout_vld
);
    logic              load;
    logic              active;
    logic [AW-1:0]     cur_addr;
    logic [WORD_W-1:0] rdata;
    logic [NBYTES-1:0] we;
    wr_req_t           req;

    assign load = !strobe_cpu_n || !strobe_ctl_n;

    sbs_burst_ctr #(.AW(AW)) u_ctr (
        .clk      (clk),
        .rst      (rst),
        .hold     (sleep),
        .load     (load),
        .sel      (!ce_n),
        .step     (!step_n),
        .ord      (burst_order_e'(order_sel)),
        .addr_in  (addr),
        .cur_addr (cur_addr),
        .active   (active)
    );

    sbs_wr_dec u_dec (
        .wr_all_n     (wr_all_n),
        .byte_wr_en_n (byte_wr_en_n),
        .byte_sel_n   (byte_sel_n),
        .req          (req)
    );

    assign we = req.lane & {NBYTES{active && !sleep && !rst}};

    sbs_array #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk   (clk),
        .we    (we),
        .addr  (cur_addr),
        .wdata (din),
        .rdata (rdata)
    );

    assign dout_vld = active && !oe_n && !req.any && !sleep;
    assign dout     = dout_vld ? rdata : '0;

    AST_SLEEP_QUIET: assert property (@(posedge clk) disable iff (rst)
        sleep |-> !dout_vld) else $error("sleep read");                     // R10
    AST_VLD_NO_WR: assert property (@(posedge clk) disable iff (rst)
        dout_vld |-> (we == '0)) else $error("read during write");          // R9
    AST_DESEL: assert property (@(posedge clk) disable iff (rst)
        (load && ce_n && !sleep) |=> !dout_vld) else $error("deselect");    // R6
endmodule

// File: tb/sync_burst_sram_tb.sv
module sync_burst_sram_tb;
    localparam int CLK_P = 10;
    localparam int DEPTH = 256;
    localparam int AW    = 8;

    logic clk = 1'b0;
    logic rst;
    logic [AW-1:0] addr;
    logic ce_n, strobe_cpu_n, strobe_ctl_n, step_n, order_sel;
    logic wr_all_n, byte_wr_en_n, oe_n, sleep;
    logic [1:0]  byte_sel_n;
    logic [17:0] din, dout;
    logic dout_vld;

    sync_burst_sram #(.DEPTH(DEPTH), .AW(AW)) u_dut (
        .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n),
        .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
        .step_n(step_n), .order_sel(order_sel), .wr_all_n(wr_all_n),
        .byte_wr_en_n(byte_wr_en_n), .byte_sel_n(byte_sel_n), .oe_n(oe_n),
        .sleep(sleep), .din(din), .dout(dout), .dout_vld(dout_vld)
    );

    always #(CLK_P/2) clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [17:0]   mem_model [DEPTH];
    logic          m_active;
    logic [AW-1:0] m_base;
    logic [1:0]    m_beat;

    bit          dir_on = 1'b0;
    string       dir_tag;
    logic [17:0] dir_exp;

    function automatic logic [AW-1:0] exp_addr();
        logic [1:0] lo;
        lo = order_sel ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [1:0] exp_lanes();
        if (!wr_all_n) return 2'b11;
        if (byte_wr_en_n) return 2'b00;
        return ~byte_sel_n;
    endfunction

    function automatic logic exp_vld();
        return m_active && !oe_n && (exp_lanes() == 2'b00) && !sleep;
    endfunction

    function automatic logic [17:0] pat(input int a);
        return 18'(a * 37 + 5) ^ 18'h2A5A5;
    endfunction

    task automatic check(input string tag, input logic [17:0] act, input logic [17:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic model_edge();
        logic [1:0] ln;
        if (rst) begin
            m_active = 1'b0; m_base = '0; m_beat = 2'd0;
        end else if (!sleep) begin
            ln = exp_lanes();
            if (m_active) begin
                if (ln[0]) mem_model[exp_addr()][8:0]  = din[8:0];
                if (ln[1]) mem_model[exp_addr()][17:9] = din[17:9];
            end
            if (!strobe_cpu_n || !strobe_ctl_n) begin
                m_base = addr; m_beat = 2'd0; m_active = !ce_n;
            end else if (!step_n) begin
                m_beat = m_beat + 2'd1;
            end
        end
    endtask

    // One clock cycle: inputs already driven; check, then edge.
    task automatic cyc();
        logic v;
        #2;
        v = exp_vld();
        check("R9 dout_vld", {17'd0, dout_vld}, {17'd0, v});
        check("R1 dout", dout, v ? mem_model[exp_addr()] : 18'd0);
        if (dir_on) check(dir_tag, dout, dir_exp);
        dir_on = 1'b0;
        @(posedge clk);
        model_edge();
        #1;
    endtask

    task automatic idle();
        strobe_cpu_n = 1; strobe_ctl_n = 1; step_n = 1; wr_all_n = 1;
        byte_wr_en_n = 1; byte_sel_n = 2'b11; oe_n = 0; sleep = 0; ce_n = 0;
    endtask

    task automatic load_at(input logic [AW-1:0] a, input bit ctl);
        idle();
        addr = a;
        if (ctl) strobe_ctl_n = 0; else strobe_cpu_n = 0;
        cyc();
        idle();
    endtask

    task automatic expect_at(input string tag, input logic [17:0] e);
        dir_on = 1'b1; dir_tag = tag; dir_exp = e;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [17:0] old;
        void'($urandom(32'd4242));
        for (int i = 0; i < DEPTH; i++) mem_model[i] = 18'd0;
        m_active = 0; m_base = '0; m_beat = 0;
        idle(); order_sel = 0; addr = '0; din = '0; rst = 1;
        @(posedge clk); model_edge(); #1;
        @(posedge clk); model_edge(); #1;
        rst = 0;
        #2;
        check("R11 reset dout_vld", {17'd0, dout_vld}, 18'd0);
        check("R11 reset dout", dout, 18'd0);

        // fill array, linear bursts with global write (R7)
        for (int b = 0; b < DEPTH; b += 4) begin
            load_at(AW'(b), b[2]);
            for (int k = 0; k < 4; k++) begin
                wr_all_n = 0; step_n = 0; din = pat(b + k);
                cyc();
            end
        end

        // R2 linear order and R5 wrap from start 0x12
        load_at(8'h12, 0);
        step_n = 0;
        expect_at("R1 first beat", pat(8'h12)); cyc();
        expect_at("R2 beat1", pat(8'h13)); cyc();
        expect_at("R2 beat2", pat(8'h10)); cyc();
        expect_at("R2 beat3", pat(8'h11)); cyc();
        expect_at("R5 wrap", pat(8'h12)); cyc();

        // R3 interleaved from 0x31
        order_sel = 1;
        load_at(8'h31, 1);
        step_n = 0;
        expect_at("R3 beat0", pat(8'h31)); cyc();
        expect_at("R3 beat1", pat(8'h30)); cyc();
        expect_at("R3 beat2", pat(8'h33)); cyc();
        expect_at("R3 beat3", pat(8'h32)); cyc();
        order_sel = 0;

        // R4 hold with step_n high
        load_at(8'h55, 0);
        cyc(); cyc();
        expect_at("R4 hold", pat(8'h55)); cyc();

        // R6 strobe overrides step_n mid burst
        step_n = 0; cyc();
        step_n = 0; strobe_ctl_n = 0; addr = 8'h66; cyc();
        idle();
        expect_at("R6 reload", pat(8'h66)); cyc();

        // R8 lane 0 only
        load_at(8'h40, 0);
        old = mem_model[8'h40];
        byte_wr_en_n = 0; byte_sel_n = 2'b10; din = 18'h3FFFF; cyc();
        idle();
        expect_at("R8 lane0 write", {old[17:9], 9'h1FF}); cyc();
        // R8 selects without enable: nothing written
        byte_sel_n = 2'b00; byte_wr_en_n = 1; din = 18'h0; cyc();
        idle();
        expect_at("R8 no enable", {old[17:9], 9'h1FF}); cyc();
        // R7 global write beats low selects
        wr_all_n = 0; byte_sel_n = 2'b11; din = 18'h15A5A; cyc();
        idle();
        expect_at("R7 global", 18'h15A5A); cyc();

        // R10 sleep freezes and blocks writes
        load_at(8'h20, 0);
        sleep = 1; wr_all_n = 0; step_n = 0; din = 18'h00001; strobe_cpu_n = 0; addr = 8'h99;
        expect_at("R10 sleep dout", 18'd0); cyc();
        idle();
        expect_at("R10 after sleep", pat(8'h20)); cyc();

        // R9 output enable gating
        oe_n = 1;
        expect_at("R9 oe high", 18'd0); cyc();
        idle();

        // R6 deselect
        ce_n = 1; strobe_cpu_n = 0; addr = 8'h70; cyc();
        idle();
        expect_at("R6 deselected", 18'd0); cyc();
        load_at(8'h70, 0);
        expect_at("R6 reselect", pat(8'h70)); cyc();

        // random phase
        for (int i = 0; i < 3000; i++) begin
            addr         = AW'($urandom);
            ce_n         = ($urandom % 8) == 0;
            strobe_cpu_n = ($urandom % 6) != 0;
            strobe_ctl_n = ($urandom % 6) != 0;
            step_n       = $urandom % 2;
            order_sel    = (i / 500) % 2;
            wr_all_n     = ($urandom % 8) != 0;
            byte_wr_en_n = ($urandom % 4) != 0;
            byte_sel_n   = 2'($urandom);
            oe_n         = ($urandom % 5) == 0;
            sleep        = ($urandom % 16) == 0;
            din          = 18'($urandom);
            cyc();
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule